// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It counts cycles of its input clock (the oscillator being controlled) and emits one single-cycle pulse per complete division period. Inside, a synchronous prescaler stage divides by either P or P+1, and two cascaded down-counters steer it: a swallow count A selects how many prescaler periods use the larger modulus, and a main count B sets how many prescaler periods make up one output period. The total division is therefore N = P·B + A input cycles.

The A and B values are sampled only at the boundary between two output periods, so an external controller (for example a fractional sequencer) may present a new pair on every period without ever producing a period built from a mix of old and new settings. Out-of-range settings are clamped to the nearest legal pair and flagged. A synchronous counter-reset input parks both counters and the prescaler; counting restarts from a fresh load when it is released. The prescaler modulus P (8 or 16) and the main-count width are parameters.

Top module: `swallow_divider`

## Requirements
- R1: For legal settings, `div_out` is high for exactly one input cycle per output period, and successive pulses are exactly P·B + A input cycles apart.
- R2: Within an output period the prescaler divides by P+1 for the first A prescaler periods and by P for the remaining B−A periods; the sum is the R1 count for every legal A from 0 up to B−1.
- R3: The modulus parameter PRESC_MOD is 8 or 16; any other value stops elaboration. The legal swallow range is 0 to PRESC_MOD−1.
- R4: The legal main count is 3 to 2^B_W−1; a programmed B of 0, 1 or 2 is replaced by 3 and raises `cfg_err`.
- R5: A programmed A above PRESC_MOD−1 is replaced by PRESC_MOD−1; after that, if A is not below the (clamped) B it is replaced by B−1. Either case raises `cfg_err`; with legal inputs `cfg_err` is low. `cfg_err` follows the inputs combinationally.
- R6: `a_val` and `b_val` are sampled only on the input-cycle edge that ends an output period (or on the first edge after reset or counter-reset release); a change made just after a pulse leaves the period in progress at its old length and sets the length of the following one.
- R7: While `cnt_reset` is high no pulse is produced; after it returns low the first pulse appears N+1 input cycles later (one load cycle plus N counted cycles).
- R8: While `rst_n` is low `div_out` is low; after release the first pulse appears N+1 input cycles later, as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (the signal being divided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_reset | input | 1 | Synchronous hold of prescaler, swallow and main counters |
| a_val | input | A_IN_W | Programmed swallow count A |
| b_val | input | B_W | Programmed main count B |
| div_out | output | 1 | One-cycle pulse per completed division period |
| cfg_err | output | 1 | High when the programmed pair is outside its legal range and has been clamped |

## Verification
A wrong count or a wrong modulus decision inside a period appears at the port as a pulse spacing that differs from P·B + A, visible on the very next pulse, so every setting is judged by measuring two consecutive spacings. Sampling of A and B at the wrong moment shows as the period in progress taking the new length instead of the old one, which the first of those two spacings catches. A counter that fails to park under counter-reset shows as a pulse during the hold or a wrong restart latency, and a broken clamp shows as a wrong `cfg_err` level or a spacing that does not match the clamped pair.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   // smallest main count the divider can run with
   localparam int unsigned B_FLOOR = 3;

   // counting phase of the control unit
   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_COUNT = 1'b1
   } phase_e;

   // prescaler moduli supported by this divider
   function automatic bit modulus_ok(input int unsigned p);
      return (p == 8) || (p == 16);
   endfunction

endpackage

// File: rtl/swdiv_sanitize.sv
module swdiv_sanitize #(
   parameter int unsigned PRESC_MOD = 8,
   parameter int unsigned A_IN_W    = 4,
   parameter int unsigned A_W       = 3,
   parameter int unsigned B_W       = 12
) (
   input  logic [A_IN_W-1:0] a_raw,
   input  logic [B_W-1:0]    b_raw,
   output logic [A_W-1:0]    a_ok,
   output logic [B_W-1:0]    b_ok,
   output logic              err
);
   import swdiv_pkg::*;

   localparam logic [B_W-1:0] B_MIN = B_W'(B_FLOOR);
   localparam logic [B_W-1:0] B_ONE = B_W'(1);
   localparam logic [A_W-1:0] A_TOP = A_W'(PRESC_MOD - 1);

   logic             b_low;
   logic [B_W-1:0]   b_c;
   logic [B_W-1:0]   b_m1;
   logic             a_over;
   logic [A_W-1:0]   a_r;
   logic [B_W-1:0]   a_ext;
   logic             a_geb;

   // main count floor
   assign b_low = (b_raw < B_MIN);
   assign b_c   = b_low ? B_MIN : b_raw;
   assign b_m1  = b_c - B_ONE;

   // swallow range: a range test only exists when the input is wider than needed
   generate
      if (A_IN_W > A_W) begin : g_a_wide
         assign a_over = (a_raw > A_IN_W'(PRESC_MOD - 1));
         assign a_r    = a_over ? A_TOP : a_raw[A_W-1:0];
      end else begin : g_a_fit
         assign a_over = 1'b0;
         assign a_r    = a_raw[A_W-1:0];
      end
   endgenerate

   // swallow must stay below the main count
   assign a_ext = B_W'(a_r);
   assign a_geb = (a_ext >= b_c);
   assign a_ok  = a_geb ? b_m1[A_W-1:0] : a_r;
   assign b_ok  = b_c;
   assign err   = b_low | a_over | a_geb;

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
   parameter int unsigned PRESC_MOD = 8,
   parameter int unsigned PC_W      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic mod_hi,
   output logic term
);
   localparam logic [PC_W-1:0] LAST_LO = PC_W'(PRESC_MOD - 1);
   localparam logic [PC_W-1:0] LAST_HI = PC_W'(PRESC_MOD);
   localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] last;

   assign last = mod_hi ? LAST_HI : LAST_LO;
   assign term = (pc == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (clear || term) begin
         pc <= '0;
      end else begin
         pc <= pc + PC_ONE;
      end
   end

   // R2
   pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> (pc <= LAST_HI) && (mod_hi || (pc <= LAST_LO)));

   // R2
   mod_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !term) |=> $stable(mod_hi));

endmodule

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl #(
   parameter int unsigned A_W = 3,
   parameter int unsigned B_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cnt_reset,
   input  logic [A_W-1:0] a_new,
   input  logic [B_W-1:0] b_new,
   input  logic           term,
   output logic           mod_hi,
   output logic           clear,
   output logic           pulse
);
   import swdiv_pkg::*;

   localparam logic [A_W-1:0] A_ONE = A_W'(1);
   localparam logic [B_W-1:0] B_ONE = B_W'(1);
   localparam logic [B_W-1:0] B_MIN = B_W'(B_FLOOR);

   logic [A_W-1:0] a_rem;
   logic [B_W-1:0] b_rem;
   phase_e         phase;
   logic           last_pp;
   logic           cyc_end;

   assign phase   = (b_rem == '0) ? PH_IDLE : PH_COUNT;
   assign clear   = cnt_reset || (phase == PH_IDLE);
   assign mod_hi  = (a_rem != '0);
   assign last_pp = (b_rem == B_ONE);
   assign cyc_end = (phase == PH_COUNT) && term && last_pp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rem <= '0;
         b_rem <= '0;
         pulse <= 1'b0;
      end else if (cnt_reset) begin
         a_rem <= '0;
         b_rem <= '0;
         pulse <= 1'b0;
      end else if (phase == PH_IDLE) begin
         a_rem <= a_new;
         b_rem <= b_new;
         pulse <= 1'b0;
      end else begin
         pulse <= cyc_end;
         if (term) begin
            if (last_pp) begin
               a_rem <= a_new;
               b_rem <= b_new;
            end else begin
               b_rem <= b_rem - B_ONE;
               if (mod_hi) begin
                  a_rem <= a_rem - A_ONE;
               end
            end
         end
      end
   end

   // R1
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R5
   a_lt_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_COUNT) |-> (B_W'(a_rem) < b_rem));

   // R4
   b_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && !cnt_reset) |=> (b_rem >= B_MIN));

   // R6
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_COUNT) && !term && !cnt_reset) |=> $stable(b_rem));

   // R7
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_reset |=> !pulse);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int unsigned PRESC_MOD = 8,
   parameter int unsigned A_IN_W    = 4,
   parameter int unsigned B_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_reset,
   input  logic [A_IN_W-1:0] a_val,
   input  logic [B_W-1:0]    b_val,
   output logic              div_out,
   output logic              cfg_err
);
   import swdiv_pkg::*;

   localparam int unsigned A_W  = $clog2(PRESC_MOD);
   localparam int unsigned PC_W = $clog2(PRESC_MOD + 1);

   // R3: elaboration-time parameter checks
   generate
      if (!modulus_ok(PRESC_MOD)) begin : g_bad_mod
         $error("swallow_divider: PRESC_MOD must be 8 or 16");
      end
      if (A_IN_W < A_W) begin : g_bad_aw
         $error("swallow_divider: A_IN_W too narrow for PRESC_MOD");
      end
      if (B_W <= A_W) begin : g_bad_bw
         $error("swallow_divider: B_W must exceed the swallow width");
      end
   endgenerate

   logic [A_W-1:0] a_ok;
   logic [B_W-1:0] b_ok;
   logic           term;
   logic           mod_hi;
   logic           clear;

   swdiv_sanitize #(
      .PRESC_MOD (PRESC_MOD),
      .A_IN_W    (A_IN_W),
      .A_W       (A_W),
      .B_W       (B_W)
   ) u_sanitize (
      .a_raw (a_val),
      .b_raw (b_val),
      .a_ok  (a_ok),
      .b_ok  (b_ok),
      .err   (cfg_err)
   );

   swdiv_ctrl #(
      .A_W (A_W),
      .B_W (B_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_reset (cnt_reset),
      .a_new     (a_ok),
      .b_new     (b_ok),
      .term      (term),
      .mod_hi    (mod_hi),
      .clear     (clear),
      .pulse     (div_out)
   );

   swdiv_prescaler #(
      .PRESC_MOD (PRESC_MOD),
      .PC_W      (PC_W)
   ) u_prescaler (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .mod_hi (mod_hi),
      .term   (term)
   );

   // R8
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !div_out);

endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic crst1 = 1'b0;
   logic crst2 = 1'b0;
   logic [3:0]  a1 = 4'd2;
   logic [6:0]  b1 = 7'd5;
   logic [3:0]  a2 = 4'd0;
   logic [11:0] b2 = 12'd3;
   logic d1, e1, d2, e2;

   int n_chk = 0;
   int n_fail = 0;
   int cur1;
   int cur2;

   always #5 clk = ~clk;

   swallow_divider #(.PRESC_MOD(8), .A_IN_W(4), .B_W(7)) u_swallow_divider (
      .clk(clk), .rst_n(rst_n), .cnt_reset(crst1), .a_val(a1), .b_val(b1),
      .div_out(d1), .cfg_err(e1));

   swallow_divider #(.PRESC_MOD(16), .A_IN_W(4), .B_W(12)) u_swallow_divider_p16 (
      .clk(clk), .rst_n(rst_n), .cnt_reset(crst2), .a_val(a2), .b_val(b2),
      .div_out(d2), .cfg_err(e2));

   function automatic int exp_n(int p, int a, int b);
      int bc = (b < 3) ? 3 : b;
      int ac = (a > p - 1) ? p - 1 : a;
      if (ac >= bc) ac = bc - 1;
      return p * bc + ac;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic gap(input int sel, output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!((sel == 1) ? d1 : d2) && g < 70000);
   endtask

   // precondition: at a negedge where the chosen instance shows a pulse
   task automatic prog(input int sel, input int a, input int b, input string req);
      int g;
      int p;
      int nn;
      bit exp_err;
      p = (sel == 1) ? 8 : 16;
      exp_err = (b < 3) || (a > p - 1) || (((a > p - 1) ? p - 1 : a) >= ((b < 3) ? 3 : b));
      nn = exp_n(p, a, b);
      if (sel == 1) begin a1 = 4'(a); b1 = 7'(b); end
      else begin a2 = 4'(a); b2 = 12'(b); end
      #1;
      check({req, " cfg_err"}, (sel == 1) ? int'(e1) : int'(e2), int'(exp_err));
      gap(sel, g);
      check("R6 old period kept", g, (sel == 1) ? cur1 : cur2);
      gap(sel, g);
      check({req, " period"}, g, nn);
      if (sel == 1) cur1 = nn; else cur2 = nn;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int g;
      int hi;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 div_out in reset", int'(d1), 0);
      check("R5 cfg_err legal", int'(e1), 0);
      cur1 = exp_n(8, 2, 5);
      cur2 = exp_n(16, 0, 3);
      rst_n = 1'b1;
      gap(1, g);
      check("R8 first pulse latency", g, cur1 + 1);
      gap(1, g);
      check("R1 period A=2 B=5", g, cur1);

      // R1 R2 sweep of every legal swallow count for small main counts
      for (int b = 3; b <= 20; b++) begin
         for (int a = 0; a < 8; a++) begin
            if (a < b) prog(1, a, b, "R2");
         end
      end
      // R4 upper end of the main count
      prog(1, 7, 127, "R4 B max");
      prog(1, 0, 127, "R4 B max A=0");
      // R4 R5 clamping
      prog(1, 0, 1, "R4 B=1");
      prog(1, 0, 0, "R4 B=0");
      prog(1, 9, 20, "R5 A over");
      prog(1, 10, 5, "R5 A over and A>=B");
      prog(1, 5, 5, "R5 A=B");
      prog(1, 15, 2, "R5 B=2 A=15");
      prog(1, 3, 9, "R1 legal again");

      // R7 counter reset hold
      crst1 = 1'b1;
      hi = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (d1) hi++;
      end
      check("R7 no pulse while held", hi, 0);
      crst1 = 1'b0;
      gap(1, g);
      check("R7 restart latency", g, cur1 + 1);
      gap(1, g);
      check("R7 period after restart", g, cur1);

      // R3 sixteen-modulus instance
      do @(negedge clk); while (!d2);
      prog(2, 0, 3, "R3 P16 A=0 B=3");
      prog(2, 15, 16, "R3 P16 A=15 B=16");
      prog(2, 15, 300, "R3 P16 A=15 B=300");
      prog(2, 7, 8, "R3 P16 A=7 B=8");
      prog(2, 15, 9, "R5 P16 A>=B");
      prog(2, 4, 1, "R4 P16 B=1");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule